// File: doc/BRIEF.md
# Transmit Frame Buffer with Replay

This block is a byte-wide transmit frame store. It sits between a host-side write port, which delivers frame bytes with an end-of-frame marker, and a MAC-side read port, which takes bytes under a valid/ready handshake. Several whole frames can be queued back to back. The next queued frame is offered on the cycle after the previous one ends.

A frame is held back until enough of it is buffered. Sending starts once the byte count of the frame reaches a programmable start level, or once the frame's end marker has been stored. The bytes of the frame being sent stay in the store until that frame completes. This lets the read side replay the frame from its first byte after a collision or a data underrun, without the host writing it again. An abort strobe drops the current frame. If its end has not yet arrived, every remaining byte up to and including the end marker is swallowed as it is written.

Capacity, the number of queued frames and the data width are parameters. The default capacity is 3072 bytes.

Top module: `txq_replay_fifo`

## Requirements
- R1: After reset, buf_empty is 1, free_bytes equals DEPTH, frames_queued is 0, rd_valid is 0 and wr_full is 0.
- R2: Bytes leave in the order they were written. rd_eof is 1 only on a frame's last byte. When that byte is taken and another frame is queued, the first byte of the next frame is presented with rd_valid on the following cycle.
- R3: While a frame has no stored end marker and fewer stored bytes than start_thresh, rd_valid stays 0. rd_valid rises on the cycle after the write that brings the count to start_thresh, or after the end marker is stored. A start_thresh of 0 starts the frame as soon as one byte is present.
- R4: A mac_collision pulse rewinds the read side to the current frame's first byte, which is presented again on a later cycle. A read handshake in the same cycle is not taken.
- R5: An underrun is a cycle in which rd_ready is 1 during a started, incomplete frame and no byte is stored. In that cycle underrun pulses. rd_valid then stays 0 until the frame's end marker has been stored, and the frame is then replayed from its first byte.
- R6: A mac_abort pulse during a complete frame drops that frame. frames_queued falls by 1, free_bytes rises by the frame length, and the next frame is presented on the following cycle. mac_abort takes priority over mac_collision and over a read handshake.
- R7: A mac_abort pulse during an incomplete frame frees its stored bytes at once. Further writes are dropped up to and including the next byte written with wr_eof. Later frames are unaffected.
- R8: wr_full is 1 when free_bytes is 0 or frames_queued equals MAX_FRAMES. A write offered while wr_full is 1 is ignored and changes neither free_bytes nor the stored data.
- R9: A frame's bytes are freed only when its end-marker byte is taken or it is aborted. Taking earlier bytes does not change free_bytes.
- R10: free_bytes is DEPTH minus the bytes held from the current frame's first byte onward. frames_queued counts frames whose end marker is stored and that are not yet released.
- R11: A write with wr_valid 1 and wr_full 0 is accepted on every cycle, with no gap between consecutive writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host offers a byte this cycle |
| wr_data | input | DATA_W | Host byte |
| wr_eof | input | 1 | Offered byte is the last of its frame |
| wr_full | output | 1 | Writes are not accepted this cycle |
| start_thresh | input | CW | Bytes a frame needs before sending starts |
| rd_valid | output | 1 | A byte is presented to the MAC |
| rd_ready | input | 1 | MAC takes the presented byte |
| rd_data | output | DATA_W | Presented byte |
| rd_eof | output | 1 | Presented byte ends its frame |
| mac_collision | input | 1 | Replay the current frame from its start |
| mac_abort | input | 1 | Drop the current frame |
| underrun | output | 1 | Pulse: MAC wanted a byte that is not yet stored |
| buf_empty | output | 1 | No byte is held |
| free_bytes | output | CW | Bytes that can still be written |
| frames_queued | output | FW | Complete frames held |

## Verification
The checker assumes that start_thresh changes only while the store is empty. The bench changes it only after the store has drained. It also assumes that mac_collision and mac_abort are one-cycle strobes, and that the MAC never holds rd_ready on a frame the checker regards as complete without data. The stimulus honours this by raising the strobes for exactly one cycle, and by writing every frame with a single end marker.

// File: rtl/txq_pkg.sv
package txq_pkg;

   typedef enum logic {
      RS_WAIT = 1'b0,
      RS_SEND = 1'b1
   } rd_state_e;

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/txf_wrap_add.sv
module txf_wrap_add #(
   parameter int DEPTH = 3072,
   parameter int AW    = 12,
   parameter int CW    = 12
) (
   input  logic [AW-1:0] base,
   input  logic [CW-1:0] step,
   output logic [AW-1:0] sum
);

   localparam bit IS_POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   generate
      if (IS_POW2) begin : g_pow2
         assign sum = AW'({{(CW-AW+1){1'b0}}, base} + {1'b0, step});
      end else begin : g_mod
         logic [CW:0] raw;
         assign raw = {{(CW-AW+1){1'b0}}, base} + {1'b0, step};
         assign sum = AW'((raw >= (CW+1)'(DEPTH)) ? raw - (CW+1)'(DEPTH) : raw);
      end
   endgenerate

endmodule

// File: rtl/txf_store.sv
module txf_store #(
   parameter int DEPTH = 3072,
   parameter int AW    = 12,
   parameter int W     = 9
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/txf_len_fifo.sv
module txf_len_fifo #(
   parameter int ENTRIES = 16,
   parameter int LW      = 12,
   parameter int NW      = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [LW-1:0] push_len,
   input  logic          pop,
   output logic [LW-1:0] head_len,
   output logic [NW-1:0] count
);

   localparam int IW = txq_pkg::idx_bits(ENTRIES);
   localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

   logic [LW-1:0] lens [ENTRIES];
   logic [IW-1:0] head_idx, tail_idx;

   always_ff @(posedge clk) begin
      if (push) lens[tail_idx] <= push_len;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_idx <= '0;
         tail_idx <= '0;
         count    <= '0;
      end else begin
         if (push) tail_idx <= (tail_idx == LAST) ? '0 : tail_idx + IW'(1);
         if (pop)  head_idx <= (head_idx == LAST) ? '0 : head_idx + IW'(1);
         case ({push, pop})
            2'b10:   count <= count + NW'(1);
            2'b01:   count <= count - NW'(1);
            default: count <= count;
         endcase
      end
   end

   assign head_len = lens[head_idx];

endmodule

// File: rtl/txq_replay_fifo.sv
module txq_replay_fifo #(
   parameter int DATA_W     = 8,
   parameter int DEPTH      = 3072,
   parameter int MAX_FRAMES = 16,
   localparam int CW        = $clog2(DEPTH + 1),
   localparam int FW        = $clog2(MAX_FRAMES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_eof,
   output logic              wr_full,
   input  logic [CW-1:0]     start_thresh,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_eof,
   input  logic              mac_collision,
   input  logic              mac_abort,
   output logic              underrun,
   output logic              buf_empty,
   output logic [CW-1:0]     free_bytes,
   output logic [FW-1:0]     frames_queued
);
   import txq_pkg::*;

   localparam int AW = idx_bits(DEPTH);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
   localparam logic [FW-1:0] FRAMES_C = FW'(MAX_FRAMES);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("txq_replay_fifo: DATA_W must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("txq_replay_fifo: DEPTH must be at least 2");
      end
      if (MAX_FRAMES < 1) begin : g_bad_frames
         $error("txq_replay_fifo: MAX_FRAMES must be at least 1");
      end
   endgenerate

   // pointer and count state
   logic [AW-1:0] wr_ptr, rd_ptr, head_ptr;
   logic [AW-1:0] wr_ptr_nx, rd_ptr_nx, head_ptr_nx;
   logic [CW-1:0] used_cnt, sent_cnt, cur_len, head_len;
   logic [FW-1:0] fq_cnt;
   logic          discard, need_full;
   rd_state_e     rstate;
   logic [DATA_W:0] rd_word;

   // control terms
   logic wr_acc, wr_store, push_len_q;
   logic has_frame, rd_avail, start_ok, go;
   logic rd_fire, frame_done, uflow;
   logic abort_do, abort_full, abort_part, release_head, rewind, discard_eff;

   assign wr_full     = (used_cnt == DEPTH_C) || (fq_cnt == FRAMES_C);
   assign wr_acc      = wr_valid && !wr_full;

   assign has_frame   = (fq_cnt != '0);
   assign rd_avail    = (sent_cnt < used_cnt);
   assign start_ok    = has_frame ||
                        (!need_full && (used_cnt != '0) && (used_cnt >= start_thresh));
   assign go          = (rstate == RS_SEND) || start_ok;

   assign abort_do    = mac_abort && (has_frame || (used_cnt != '0));
   assign abort_full  = abort_do && has_frame;
   assign abort_part  = abort_do && !has_frame;

   assign rd_fire     = go && rd_avail && rd_ready && !mac_abort && !mac_collision;
   assign frame_done  = rd_fire && rd_word[DATA_W];
   assign uflow       = go && rd_ready && !rd_avail && !has_frame &&
                        !mac_abort && !mac_collision;

   assign release_head = frame_done || abort_full;
   assign rewind       = (mac_collision && !mac_abort) || uflow;

   assign discard_eff = discard || abort_part;
   assign wr_store    = wr_acc && !discard_eff;
   assign push_len_q  = wr_store && wr_eof;

   // storage of byte plus end marker
   txf_store #(
      .DEPTH (DEPTH),
      .AW    (AW),
      .W     (DATA_W + 1)
   ) u_store (
      .clk   (clk),
      .we    (wr_store),
      .waddr (wr_ptr),
      .wdata ({wr_eof, wr_data}),
      .raddr (rd_ptr),
      .rdata (rd_word)
   );

   // lengths of frames whose end marker is stored
   txf_len_fifo #(
      .ENTRIES (MAX_FRAMES),
      .LW      (CW),
      .NW      (FW)
   ) u_lens (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push_len_q),
      .push_len (cur_len + CW'(1)),
      .pop      (release_head),
      .head_len (head_len),
      .count    (fq_cnt)
   );

   txf_wrap_add #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_wr_step (
      .base (wr_ptr),   .step (CW'(1)),   .sum (wr_ptr_nx)
   );
   txf_wrap_add #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_rd_step (
      .base (rd_ptr),   .step (CW'(1)),   .sum (rd_ptr_nx)
   );
   txf_wrap_add #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_head_step (
      .base (head_ptr), .step (head_len), .sum (head_ptr_nx)
   );

   // write side
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         cur_len <= '0;
         discard <= 1'b0;
      end else begin
         if (wr_store) begin
            wr_ptr  <= wr_ptr_nx;
            cur_len <= wr_eof ? '0 : cur_len + CW'(1);
         end else if (abort_part) begin
            cur_len <= '0;
         end
         discard <= discard_eff && !(wr_acc && wr_eof);
      end
   end

   // occupancy from the current frame's first byte
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         used_cnt <= '0;
      end else if (abort_part) begin
         used_cnt <= '0;
      end else begin
         used_cnt <= used_cnt + CW'(wr_store) - (release_head ? head_len : '0);
      end
   end

   // read side
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_ptr  <= '0;
         rd_ptr    <= '0;
         sent_cnt  <= '0;
         rstate    <= RS_WAIT;
         need_full <= 1'b0;
      end else begin
         if (abort_part) begin
            head_ptr <= wr_ptr;
            rd_ptr   <= wr_ptr;
            sent_cnt <= '0;
         end else if (release_head) begin
            head_ptr <= head_ptr_nx;
            rd_ptr   <= head_ptr_nx;
            sent_cnt <= '0;
         end else if (rewind) begin
            rd_ptr   <= head_ptr;
            sent_cnt <= '0;
         end else if (rd_fire) begin
            rd_ptr   <= rd_ptr_nx;
            sent_cnt <= sent_cnt + CW'(1);
         end

         if (abort_do || release_head || rewind) rstate <= RS_WAIT;
         else if (go)                            rstate <= RS_SEND;

         if (abort_do || release_head) need_full <= 1'b0;
         else if (uflow)               need_full <= 1'b1;
      end
   end

   assign rd_valid      = go && rd_avail;
   assign rd_data       = rd_word[DATA_W-1:0];
   assign rd_eof        = rd_word[DATA_W];
   assign underrun      = uflow;
   assign buf_empty     = (used_cnt == '0);
   assign free_bytes    = DEPTH_C - used_cnt;
   assign frames_queued = fq_cnt;

endmodule

// File: rtl/txq_replay_fifo_chk.sv
module txq_replay_fifo_chk #(
   parameter int DEPTH      = 3072,
   parameter int MAX_FRAMES = 16,
   localparam int CW        = $clog2(DEPTH + 1),
   localparam int FW        = $clog2(MAX_FRAMES + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_valid,
   input logic          wr_eof,
   input logic          wr_full,
   input logic [CW-1:0] start_thresh,
   input logic          rd_valid,
   input logic          rd_ready,
   input logic          rd_eof,
   input logic          mac_collision,
   input logic          mac_abort,
   input logic          underrun,
   input logic          buf_empty,
   input logic [CW-1:0] free_bytes,
   input logic [FW-1:0] frames_queued
);

   // R10
   no_data_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_empty |-> !rd_valid);

   // R3
   start_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> (frames_queued != '0) ||
                          ((CW'(DEPTH) - free_bytes) >= start_thresh));

   // R5
   underrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> (!rd_valid || frames_queued != '0));

   // R11
   free_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (free_bytes < $past(free_bytes)) |-> (free_bytes == $past(free_bytes) - CW'(1)));

   // R10
   frames_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frames_queued > $past(frames_queued)) |->
         (frames_queued == $past(frames_queued) + FW'(1)));

   // R9
   eof_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_ready && rd_eof && !mac_abort && !mac_collision &&
       !(wr_valid && wr_eof && !wr_full))
      |=> (frames_queued == $past(frames_queued) - FW'(1)));

endmodule

bind txq_replay_fifo txq_replay_fifo_chk #(
   .DEPTH      (DEPTH),
   .MAX_FRAMES (MAX_FRAMES)
) u_chk (.*);

// File: tb/txq_replay_fifo_test.sv
`timescale 1ns/1ps
module txq_replay_fifo_test;

   localparam int DW = 8;
   localparam int DEPTH = 16;
   localparam int MAXF = 4;
   localparam int CW = $clog2(DEPTH + 1);
   localparam int FW = $clog2(MAXF + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0, wr_eof = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_full;
   logic [CW-1:0] start_thresh = '0;
   logic          rd_valid, rd_eof, underrun, buf_empty;
   logic          rd_ready = 1'b0, mac_collision = 1'b0, mac_abort = 1'b0;
   logic [DW-1:0] rd_data;
   logic [CW-1:0] free_bytes;
   logic [FW-1:0] frames_queued;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   txq_replay_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .MAX_FRAMES(MAXF)) uut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_eof(wr_eof), .wr_full(wr_full), .start_thresh(start_thresh),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
      .rd_eof(rd_eof), .mac_collision(mac_collision), .mac_abort(mac_abort),
      .underrun(underrun), .buf_empty(buf_empty), .free_bytes(free_bytes),
      .frames_queued(frames_queued)
   );

   // row: wv we wd rr col ab | ev ed eu ef
   localparam int NV = 26;
   localparam logic [27:0] VEC [NV] = '{
      {1'b1,1'b0,8'h10,1'b1,1'b0,1'b0, 1'b0,8'h00,1'b0,5'd16},
      {1'b1,1'b0,8'h11,1'b1,1'b0,1'b0, 1'b0,8'h00,1'b0,5'd15},
      {1'b1,1'b0,8'h12,1'b1,1'b0,1'b0, 1'b0,8'h00,1'b0,5'd14},
      {1'b1,1'b1,8'h13,1'b1,1'b0,1'b0, 1'b1,8'h10,1'b0,5'd13},
      {1'b1,1'b0,8'h20,1'b1,1'b0,1'b0, 1'b1,8'h11,1'b0,5'd12},
      {1'b1,1'b1,8'h21,1'b1,1'b0,1'b0, 1'b1,8'h12,1'b0,5'd11},
      {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0, 1'b1,8'h13,1'b0,5'd10},
      {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0, 1'b1,8'h20,1'b0,5'd14},
      {1'b0,1'b0,8'h00,1'b1,1'b1,1'b0, 1'b1,8'h21,1'b0,5'd14},
      {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0, 1'b1,8'h20,1'b0,5'd14},
      {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0, 1'b1,8'h21,1'b0,5'd14},
      {1'b1,1'b0,8'h30,1'b1,1'b0,1'b0, 1'b0,8'h00,1'b0,5'd16},
      {1'b1,1'b0,8'h31,1'b1,1'b0,1'b0, 1'b0,8'h00,1'b0,5'd15},
      {1'b1,1'b0,8'h32,1'b1,1'b0,1'b0, 1'b0,8'h00,1'b0,5'd14},
      {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0, 1'b1,8'h30,1'b0,5'd13},
      {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0, 1'b1,8'h31,1'b0,5'd13},
      {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0, 1'b1,8'h32,1'b0,5'd13},
      {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0, 1'b0,8'h00,1'b1,5'd13},
      {1'b1,1'b0,8'h33,1'b1,1'b0,1'b0, 1'b0,8'h00,1'b0,5'd13},
      {1'b1,1'b1,8'h34,1'b1,1'b0,1'b0, 1'b0,8'h00,1'b0,5'd12},
      {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0, 1'b1,8'h30,1'b0,5'd11},
      {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0, 1'b1,8'h31,1'b0,5'd11},
      {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0, 1'b1,8'h32,1'b0,5'd11},
      {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0, 1'b1,8'h33,1'b0,5'd11},
      {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0, 1'b1,8'h34,1'b0,5'd11},
      {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0, 1'b0,8'h00,1'b0,5'd16}
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input logic wv, input logic we, input logic [7:0] wd,
                        input logic rr, input logic col, input logic ab);
      @(negedge clk);
      wr_valid = wv; wr_eof = we; wr_data = wd;
      rd_ready = rr; mac_collision = col; mac_abort = ab;
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 empty", int'(buf_empty), 1);
      check("R1 free", int'(free_bytes), DEPTH);
      check("R1 frames", int'(frames_queued), 0);
      check("R1 rd_valid", int'(rd_valid), 0);
      check("R1 wr_full", int'(wr_full), 0);

      // table: threshold 3, back to back, collision, underrun replay
      start_thresh = CW'(3);
      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][27], VEC[i][26], VEC[i][25:18], VEC[i][17], VEC[i][16], VEC[i][15]);
         check($sformatf("R3/R2/R4 row%0d rd_valid", i), int'(rd_valid), int'(VEC[i][14]));
         if (VEC[i][14])
            check($sformatf("R2/R4 row%0d rd_data", i), int'(rd_data), int'(VEC[i][13:6]));
         check($sformatf("R5 row%0d underrun", i), int'(underrun), int'(VEC[i][5]));
         check($sformatf("R10 row%0d free", i), int'(free_bytes), int'(VEC[i][4:0]));
      end

      // threshold zero and abort of an incomplete frame
      drive(0,0,8'h00,0,0,0);
      start_thresh = '0;
      drive(1,0,8'h50,0,0,0);
      check("R3 zero-level before byte", int'(rd_valid), 0);
      drive(0,0,8'h00,0,0,0);
      check("R3 zero-level valid", int'(rd_valid), 1);
      check("R3 zero-level data", int'(rd_data), 8'h50);
      drive(0,0,8'h00,0,0,1);
      drive(1,0,8'h55,0,0,0);
      check("R7 free after abort", int'(free_bytes), DEPTH);
      check("R7 no valid after abort", int'(rd_valid), 0);
      drive(1,1,8'h56,0,0,0);
      check("R7 dropped byte free", int'(free_bytes), DEPTH);
      drive(1,0,8'h60,0,0,0);
      check("R7 dropped frame free", int'(free_bytes), DEPTH);
      check("R7 dropped frame count", int'(frames_queued), 0);
      drive(1,1,8'h61,0,0,0);
      check("R7 next frame valid", int'(rd_valid), 1);
      check("R7 next frame data", int'(rd_data), 8'h60);

      // abort of a complete frame
      drive(1,1,8'h70,0,0,0);
      check("R10 frames", int'(frames_queued), 1);
      check("R10 free", int'(free_bytes), DEPTH - 2);
      drive(0,0,8'h00,0,1,1);
      check("R10 frames two", int'(frames_queued), 2);
      drive(0,0,8'h00,1,0,0);
      check("R6 frames after abort", int'(frames_queued), 1);
      check("R6 free after abort", int'(free_bytes), DEPTH - 1);
      check("R6 next valid", int'(rd_valid), 1);
      check("R6 next data", int'(rd_data), 8'h70);
      check("R6 next eof", int'(rd_eof), 1);
      drive(0,0,8'h00,0,0,0);
      check("R9 drained", int'(buf_empty), 1);

      // byte capacity
      for (int i = 0; i < DEPTH; i++) begin
         drive(1, (i == DEPTH - 1), 8'(8'h80 + i), 0, 0, 0);
         check($sformatf("R11 write %0d accepted", i), int'(wr_full), 0);
      end
      drive(1,1,8'hEE,0,0,0);
      check("R8 full flag", int'(wr_full), 1);
      check("R8 free zero", int'(free_bytes), 0);
      for (int j = 0; j < DEPTH; j++) begin
         drive(0,0,8'h00,1,0,0);
         if (j == 0) check("R8 ignored write", int'(free_bytes), 0);
         if (j == DEPTH - 1) check("R9 not freed before eof", int'(free_bytes), 0);
         check($sformatf("R2 byte %0d valid", j), int'(rd_valid), 1);
         check($sformatf("R2 byte %0d data", j), int'(rd_data), 8'h80 + j);
         check($sformatf("R2 byte %0d eof", j), int'(rd_eof), int'(j == DEPTH - 1));
      end
      drive(0,0,8'h00,0,0,0);
      check("R9 freed", int'(free_bytes), DEPTH);
      check("R9 frames", int'(frames_queued), 0);

      // frame-count capacity
      for (int i = 0; i < MAXF; i++) drive(1,1,8'(8'h90 + i),0,0,0);
      drive(1,1,8'hAA,0,0,0);
      check("R8 frame limit full", int'(wr_full), 1);
      check("R8 frame limit free", int'(free_bytes), DEPTH - MAXF);
      check("R8 frame limit count", int'(frames_queued), MAXF);
      for (int i = 0; i < MAXF; i++) begin
         drive(0,0,8'h00,1,0,0);
         if (i == 0) check("R8 ignored frame", int'(frames_queued), MAXF);
         check($sformatf("R2 short frame %0d data", i), int'(rd_data), 8'h90 + i);
         check($sformatf("R2 short frame %0d valid", i), int'(rd_valid), 1);
      end
      drive(0,0,8'h00,0,0,0);
      check("R10 empty at end", int'(buf_empty), 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule